// File: doc/BRIEF.md
# PCI configuration access translator

This block turns a local configuration request into one or two dword-wide configuration cycles. A request names a device, a function, a byte offset and an access size of 1, 2 or 4 bytes. It also carries a read/write flag and write data. The block builds a Type 0 configuration address in which the device is selected by a single one-hot address line. Every access begins with a read of the aligned dword. A read returns the addressed lanes, right-justified. A write merges its lanes into the dword it read and writes the whole dword back.

Failed transactions give a "not found" response carrying all-ones data. A transaction fails when the target aborts, when the device number cannot be addressed, or when the external port names the host's own slot. Only one request is in flight at a time. A mode output tells the surrounding bridge to steer its window to configuration space for exactly the span of the bus cycles.

Top module: `cfgx_translator`

## Requirements
- R1: The cycle address is the OR of three terms: a single bit at position 13 + device, the function shifted left by 8, and the offset with bits 1:0 forced to zero.
- R2: A request is refused when the device number is above 18 or the formed address is 0x100000 or higher. No bus cycle is issued, and the response is not-found (`rsp_ok`=0) with data 0xFFFFFFFF.
- R3: With `req_internal`=0, device 3 is refused exactly as in R2. With `req_internal`=1, device 3 is reached normally.
- R4: A successful read returns (dword >> 8·(offset mod 4)) AND (0xFFFFFFFF >> 8·(4 − size)), where `req_size` holds the byte count.
- R5: A write first reads the aligned dword. It then writes back that dword with only the lanes selected by the size mask, shifted by the offset, replaced. Write-data bits above the access size are ignored. A successful write returns `rsp_ok`=1 and data 0.
- R6: If the target aborts the read, the response is not-found with 0xFFFFFFFF data, and no write-back is issued.
- R7: If the target aborts the write-back, the response is not-found with 0xFFFFFFFF data.
- R8: An abort indication seen while no access is running is discarded when the next access starts, and does not fail it.
- R9: `cfg_mode` is high on every cycle on which `cyc_valid` is high. It is low again by the time the response appears.
- R10: `req_ready` is high only while idle. Each accepted request yields exactly one `rsp_valid` pulse, one cycle long, and `req_ready` returns only after it.
- R11: After reset the block is idle: `req_ready`=1, and `rsp_valid`, `cyc_valid` and `cfg_mode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_internal | input | 1 | Request comes from the internal port (may reach the host slot) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | DEV_W | Device number |
| req_func | input | FUNC_W | Function number |
| req_ofs | input | OFS_W | Byte offset in configuration space |
| req_size | input | SIZE_W | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | 1 = success, 0 = not found |
| rsp_rdata | output | 32 | Read result, or all-ones on failure |
| cfg_mode | output | 1 | Window steered to configuration space |
| cyc_valid | output | 1 | Configuration bus cycle requested |
| cyc_write | output | 1 | Bus cycle is a write |
| cyc_addr | output | 32 | Configuration cycle address |
| cyc_wdata | output | 32 | Merged dword for the write-back |
| cyc_done | input | 1 | Bus cycle completes this clock |
| cyc_abort | input | 1 | Master-abort indication |
| cyc_rdata | input | 32 | Dword read by the bus cycle |

## Verification
The main path is tried with reads of every size at all four byte lanes, including a 4-byte access at a misaligned offset. This separates the shift from the mask and shows whether the mask is derived from the size. Sub-dword writes carry stray bits above their size and are each followed by a full-dword read. These tell a true lane merge from a raw overwrite, and show whether the stray bits leak. Failure patterns are also covered. The target aborts at read time and, separately, at write-back time, using an absent slot, a non-zero function and a read-only slot. Further requests use device 3 from each port, devices 6, 7, 18 and 19, and a stale abort raised while idle. Together these show which refusals happen before any bus cycle and which come from the target.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_ARM,
      ST_READ,
      ST_WRITE,
      ST_RESTORE,
      ST_RESP
   } cfgx_state_e;

   localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;
endpackage

// File: rtl/cfgx_addr_gen.sv
module cfgx_addr_gen #(
   parameter int unsigned DEV_W      = 5,
   parameter int unsigned FUNC_W     = 3,
   parameter int unsigned OFS_W      = 8,
   parameter int unsigned IDSEL_BASE = 13,
   parameter int unsigned MAX_DEV    = 18,
   parameter int unsigned HOST_SLOT  = 3,
   parameter logic [31:0] SPAN       = 32'h0010_0000
) (
   input  logic [DEV_W-1:0]  dev,
   input  logic [FUNC_W-1:0] func,
   input  logic [OFS_W-1:0]  ofs,
   input  logic              internal,
   output logic [31:0]       addr,
   output logic              refuse
);
   logic [63:0] full;
   logic        bad_dev;
   logic        bad_span;
   logic        host_hit;

   always_comb begin
      full     = (64'd1 << (IDSEL_BASE + 32'(dev)))
               | (64'(func) << 8)
               | 64'({ofs[OFS_W-1:2], 2'b00});
      bad_dev  = 32'(dev) > MAX_DEV;
      bad_span = full >= 64'(SPAN);
      host_hit = !internal && (32'(dev) == HOST_SLOT);
      refuse   = bad_dev | bad_span | host_hit;
      addr     = full[31:0];
   end
endmodule

// File: rtl/cfgx_lanes.sv
module cfgx_lanes #(
   parameter int unsigned SIZE_W     = 3,
   parameter bit          MASK_WDATA = 1'b1
) (
   input  logic [1:0]        ofs_lo,
   input  logic [SIZE_W-1:0] size,
   input  logic [31:0]       dword,
   input  logic [31:0]       wdata,
   output logic [31:0]       rd_field,
   output logic [31:0]       merged
);
   logic [2:0]  nbytes;
   logic [4:0]  sh;
   logic [31:0] mask;
   logic [31:0] lane_mask;
   logic [31:0] wsrc;

   always_comb begin
      nbytes    = (size == '0 || 32'(size) > 4) ? 3'd4 : 3'(size);
      mask      = 32'hFFFF_FFFF >> {3'(3'd4 - nbytes), 3'b000};
      sh        = {ofs_lo, 3'b000};
      lane_mask = mask << sh;
      rd_field  = (dword >> sh) & mask;
      merged    = (dword & ~lane_mask) | (wsrc << sh);
   end

   generate
      if (MASK_WDATA) begin : g_clip
         assign wsrc = wdata & mask;
      end else begin : g_raw
         assign wsrc = wdata;
      end
   endgenerate
endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
   import cfgx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        refuse,
   input  logic        is_write,
   input  logic [31:0] rd_field,
   input  logic        cyc_done,
   input  logic        cyc_abort,
   input  logic [31:0] cyc_rdata,
   output logic        req_ready,
   output logic        accept,
   output logic        cfg_mode,
   output logic        cyc_valid,
   output logic        cyc_write,
   output logic [31:0] rd_dword,
   output logic        rsp_valid,
   output logic        rsp_ok,
   output logic [31:0] rsp_rdata
);
   cfgx_state_e state_q;
   logic        abort_q;
   logic        err_q;
   logic        hit_abort;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign cfg_mode  = (state_q == ST_ARM) || (state_q == ST_READ) || (state_q == ST_WRITE);
   assign cyc_valid = (state_q == ST_READ) || (state_q == ST_WRITE);
   assign cyc_write = (state_q == ST_WRITE);
   assign rsp_valid = (state_q == ST_RESP);
   assign hit_abort = abort_q | cyc_abort;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         abort_q   <= 1'b0;
         err_q     <= 1'b0;
         rd_dword  <= '0;
         rsp_ok    <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         if (cyc_abort) abort_q <= 1'b1;
         case (state_q)
            ST_IDLE: if (accept) state_q <= ST_CHECK;
            ST_CHECK: begin
               if (refuse) begin
                  rsp_ok    <= 1'b0;
                  rsp_rdata <= ALL_ONES;
                  state_q   <= ST_RESP;
               end else begin
                  state_q <= ST_ARM;
               end
            end
            ST_ARM: begin
               abort_q <= 1'b0;
               err_q   <= 1'b0;
               state_q <= ST_READ;
            end
            ST_READ: if (cyc_done) begin
               rd_dword <= cyc_rdata;
               if (hit_abort) begin
                  err_q   <= 1'b1;
                  abort_q <= 1'b0;
                  state_q <= ST_RESTORE;
               end else begin
                  state_q <= is_write ? ST_WRITE : ST_RESTORE;
               end
            end
            ST_WRITE: if (cyc_done) begin
               if (hit_abort) begin
                  err_q   <= 1'b1;
                  abort_q <= 1'b0;
               end
               state_q <= ST_RESTORE;
            end
            ST_RESTORE: begin
               rsp_ok    <= !err_q;
               rsp_rdata <= err_q ? ALL_ONES : (is_write ? '0 : rd_field);
               state_q   <= ST_RESP;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R10
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R10
   ready_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_ready) |-> $past(rsp_valid));
   // R9
   mode_during_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid |-> cfg_mode);
   // R5
   wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_write && !$past(cyc_write)) |-> $past(cyc_done && cyc_valid));
endmodule

// File: rtl/cfgx_translator.sv
module cfgx_translator #(
   parameter int unsigned DEV_W      = 5,
   parameter int unsigned FUNC_W     = 3,
   parameter int unsigned OFS_W      = 8,
   parameter int unsigned SIZE_W     = 3,
   parameter int unsigned IDSEL_BASE = 13,
   parameter int unsigned MAX_DEV    = 18,
   parameter int unsigned HOST_SLOT  = 3,
   parameter logic [31:0] SPAN       = 32'h0010_0000,
   parameter bit          MASK_WDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_internal,
   input  logic              req_write,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [FUNC_W-1:0] req_func,
   input  logic [OFS_W-1:0]  req_ofs,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic              rsp_ok,
   output logic [31:0]       rsp_rdata,
   output logic              cfg_mode,
   output logic              cyc_valid,
   output logic              cyc_write,
   output logic [31:0]       cyc_addr,
   output logic [31:0]       cyc_wdata,
   input  logic              cyc_done,
   input  logic              cyc_abort,
   input  logic [31:0]       cyc_rdata
);
   localparam int unsigned FUNC_TOP = FUNC_W + 8;

   generate
      if (IDSEL_BASE + MAX_DEV > 31) begin : g_bad_idsel
         $error("IDSEL line for MAX_DEV falls outside the 32-bit address");
      end
      if (FUNC_TOP > IDSEL_BASE) begin : g_bad_func
         $error("function field overlaps the IDSEL lines");
      end
      if (OFS_W != 8) begin : g_bad_ofs
         $error("offset field must be 8 bits wide");
      end
      if (HOST_SLOT >= (1 << DEV_W)) begin : g_bad_host
         $error("HOST_SLOT is not encodable in DEV_W bits");
      end
   endgenerate

   logic              accept;
   logic              refuse;
   logic [31:0]       rd_dword;
   logic [31:0]       rd_field;
   logic              q_internal;
   logic              q_write;
   logic [DEV_W-1:0]  q_dev;
   logic [FUNC_W-1:0] q_func;
   logic [OFS_W-1:0]  q_ofs;
   logic [SIZE_W-1:0] q_size;
   logic [31:0]       q_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_internal <= 1'b0;
         q_write    <= 1'b0;
         q_dev      <= '0;
         q_func     <= '0;
         q_ofs      <= '0;
         q_size     <= '0;
         q_wdata    <= '0;
      end else if (accept) begin
         q_internal <= req_internal;
         q_write    <= req_write;
         q_dev      <= req_dev;
         q_func     <= req_func;
         q_ofs      <= req_ofs;
         q_size     <= req_size;
         q_wdata    <= req_wdata;
      end
   end

   cfgx_addr_gen #(
      .DEV_W(DEV_W), .FUNC_W(FUNC_W), .OFS_W(OFS_W), .IDSEL_BASE(IDSEL_BASE),
      .MAX_DEV(MAX_DEV), .HOST_SLOT(HOST_SLOT), .SPAN(SPAN)
   ) u_addr (
      .dev(q_dev), .func(q_func), .ofs(q_ofs), .internal(q_internal),
      .addr(cyc_addr), .refuse(refuse)
   );

   cfgx_lanes #(.SIZE_W(SIZE_W), .MASK_WDATA(MASK_WDATA)) u_lanes (
      .ofs_lo(q_ofs[1:0]), .size(q_size), .dword(rd_dword), .wdata(q_wdata),
      .rd_field(rd_field), .merged(cyc_wdata)
   );

   cfgx_seq u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .refuse(refuse),
      .is_write(q_write), .rd_field(rd_field), .cyc_done(cyc_done),
      .cyc_abort(cyc_abort), .cyc_rdata(cyc_rdata), .req_ready(req_ready),
      .accept(accept), .cfg_mode(cfg_mode), .cyc_valid(cyc_valid),
      .cyc_write(cyc_write), .rd_dword(rd_dword), .rsp_valid(rsp_valid),
      .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata)
   );

   // R1
   addr_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid |-> (cyc_addr[1:0] == 2'b00) && ($countones(cyc_addr[31:IDSEL_BASE]) == 1));
   // R2
   addr_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid |-> (cyc_addr < SPAN));
   // R3
   host_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid |-> !(32'(q_dev) == HOST_SLOT && !q_internal));
   // R1
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && $past(cyc_valid)) |-> $stable(cyc_addr));
endmodule

// File: tb/test_cfgx_translator.sv
`timescale 1ns/1ps
module test_cfgx_translator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_internal = 1'b0;
   logic        req_write = 1'b0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_func = '0;
   logic [7:0]  req_ofs = '0;
   logic [2:0]  req_size = 3'd4;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_ok;
   logic [31:0] rsp_rdata;
   logic        cfg_mode, cyc_valid, cyc_write;
   logic [31:0] cyc_addr, cyc_wdata;
   logic        m_done = 1'b0, m_abort = 1'b0, force_abort = 1'b0;
   logic [31:0] m_rdata = '0;
   logic        cyc_abort;

   assign cyc_abort = m_abort | force_abort;

   always #10 clk = ~clk;

   cfgx_translator i_cfgx_translator (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_internal(req_internal), .req_write(req_write), .req_dev(req_dev),
      .req_func(req_func), .req_ofs(req_ofs), .req_size(req_size),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
      .rsp_rdata(rsp_rdata), .cfg_mode(cfg_mode), .cyc_valid(cyc_valid),
      .cyc_write(cyc_write), .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata),
      .cyc_done(m_done), .cyc_abort(cyc_abort), .cyc_rdata(m_rdata)
   );

   // behavioural target: slots 1,2,3 present at function 0, slot 2 read-only
   logic [31:0] mem [0:6][0:63];
   int          ncyc_cnt = 0;
   int          mode_bad = 0;
   int          lat = 0;
   logic [31:0] last_addr = '0;
   int          n_acc = 0, n_rsp = 0, n_double = 0;
   logic        prev_rsp = 1'b0;

   initial begin
      for (int s = 0; s < 7; s++)
         for (int i = 0; i < 64; i++)
            mem[s][i] = {4'hA, 4'(s), 8'(i), 16'hBEEF};
   end

   always @(posedge clk) begin : model
      int  slot;
      bit  present;
      slot = -1;
      for (int k = 0; k < 7; k++)
         if (cyc_addr[31:13] == 19'(1 << k)) slot = k;
      present = (slot >= 1) && (slot <= 3) && (cyc_addr[10:8] == 3'd0);
      m_done  <= 1'b0;
      m_abort <= 1'b0;
      if (rst_n) begin
         if (cyc_valid && !cfg_mode) mode_bad <= mode_bad + 1;
         if (cyc_valid && !m_done) begin
            if (lat == 1) begin
               lat       <= 0;
               m_done    <= 1'b1;
               ncyc_cnt  <= ncyc_cnt + 1;
               last_addr <= cyc_addr;
               if (!cyc_write) begin
                  m_rdata <= present ? mem[slot][cyc_addr[7:2]] : 32'hFFFF_FFFF;
                  m_abort <= !present;
               end else if (present && slot != 2) begin
                  mem[slot][cyc_addr[7:2]] <= cyc_wdata;
               end else begin
                  m_abort <= 1'b1;
               end
            end else begin
               lat <= lat + 1;
            end
         end
         if (req_valid && req_ready) n_acc <= n_acc + 1;
         if (rsp_valid) n_rsp <= n_rsp + 1;
         if (rsp_valid && prev_rsp) n_double <= n_double + 1;
         prev_rsp <= rsp_valid;
      end
   end

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit cond, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   typedef struct packed {
      logic        intl;
      logic        wr;
      logic [4:0]  dev;
      logic [2:0]  func;
      logic [7:0]  ofs;
      logic [2:0]  size;
      logic [31:0] wdata;
      logic        ok;
      logic [31:0] rdata;
      logic [1:0]  ncyc;
      logic [31:0] addr;
   } vec_t;

   // intl wr dev func ofs size wdata | ok rdata ncyc addr
   localparam int NV = 23;
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b0,5'd1,3'd0,8'h00,3'd4,32'h0,        1'b1,32'hA100BEEF,2'd1,32'h0000_4000}, // R1 R4
      '{1'b0,1'b0,5'd1,3'd0,8'h06,3'd2,32'h0,        1'b1,32'h0000A101,2'd1,32'h0000_4004}, // R4
      '{1'b0,1'b0,5'd1,3'd0,8'h03,3'd1,32'h0,        1'b1,32'h000000A1,2'd1,32'h0000_4000}, // R4
      '{1'b0,1'b0,5'd1,3'd0,8'h01,3'd4,32'h0,        1'b1,32'h00A100BE,2'd1,32'h0000_4000}, // R4
      '{1'b0,1'b1,5'd1,3'd0,8'h09,3'd1,32'hFFFFFF77, 1'b1,32'h00000000,2'd2,32'h0000_4008}, // R5
      '{1'b0,1'b0,5'd1,3'd0,8'h08,3'd4,32'h0,        1'b1,32'hA10277EF,2'd1,32'h0000_4008}, // R5
      '{1'b0,1'b1,5'd1,3'd0,8'h0E,3'd2,32'hABCD1234, 1'b1,32'h00000000,2'd2,32'h0000_400C}, // R5
      '{1'b0,1'b0,5'd1,3'd0,8'h0C,3'd4,32'h0,        1'b1,32'h1234BEEF,2'd1,32'h0000_400C}, // R5
      '{1'b0,1'b1,5'd1,3'd0,8'h10,3'd4,32'hCAFEF00D, 1'b1,32'h00000000,2'd2,32'h0000_4010}, // R5
      '{1'b0,1'b0,5'd1,3'd0,8'h10,3'd4,32'h0,        1'b1,32'hCAFEF00D,2'd1,32'h0000_4010}, // R5
      '{1'b0,1'b0,5'd1,3'd2,8'h00,3'd4,32'h0,        1'b0,32'hFFFFFFFF,2'd1,32'h0000_4200}, // R6 R1
      '{1'b0,1'b1,5'd2,3'd0,8'h04,3'd4,32'h0,        1'b0,32'hFFFFFFFF,2'd2,32'h0000_8004}, // R7
      '{1'b0,1'b0,5'd2,3'd0,8'h04,3'd4,32'h0,        1'b1,32'hA201BEEF,2'd1,32'h0000_8004}, // R7
      '{1'b0,1'b1,5'd5,3'd0,8'h00,3'd4,32'h12345678, 1'b0,32'hFFFFFFFF,2'd1,32'h0004_0000}, // R6
      '{1'b0,1'b0,5'd3,3'd0,8'h00,3'd4,32'h0,        1'b0,32'hFFFFFFFF,2'd0,32'h0},         // R3
      '{1'b1,1'b0,5'd3,3'd0,8'h00,3'd4,32'h0,        1'b1,32'hA300BEEF,2'd1,32'h0001_0000}, // R3
      '{1'b0,1'b0,5'd7,3'd0,8'h00,3'd4,32'h0,        1'b0,32'hFFFFFFFF,2'd0,32'h0},         // R2
      '{1'b0,1'b0,5'd19,3'd0,8'h00,3'd4,32'h0,       1'b0,32'hFFFFFFFF,2'd0,32'h0},         // R2
      '{1'b0,1'b0,5'd18,3'd0,8'h00,3'd4,32'h0,       1'b0,32'hFFFFFFFF,2'd0,32'h0},         // R2
      '{1'b0,1'b0,5'd6,3'd7,8'hFC,3'd4,32'h0,        1'b0,32'hFFFFFFFF,2'd1,32'h0008_07FC}, // R2 R1
      '{1'b0,1'b0,5'd0,3'd0,8'h20,3'd4,32'h0,        1'b0,32'hFFFFFFFF,2'd1,32'h0000_2020}, // R1 R6
      '{1'b1,1'b1,5'd3,3'd0,8'h02,3'd2,32'h0000BBBB, 1'b1,32'h00000000,2'd2,32'h0001_0000}, // R3 R5
      '{1'b1,1'b0,5'd3,3'd0,8'h00,3'd4,32'h0,        1'b1,32'hBBBBBEEF,2'd1,32'h0001_0000}  // R3 R5
   };

   int n_req = 0;
   bit busy_ready_seen = 0;

   task automatic do_req(input vec_t v, output logic ok, output logic [31:0] d,
                         output int nc, output logic [31:0] la, output logic mode);
      int c0;
      int t;
      @(negedge clk);
      c0           = ncyc_cnt;
      req_internal = v.intl;
      req_write    = v.wr;
      req_dev      = v.dev;
      req_func     = v.func;
      req_ofs      = v.ofs;
      req_size     = v.size;
      req_wdata    = v.wdata;
      req_valid    = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n_req++;
      t = 0;
      while (!rsp_valid && t < 200) begin
         if (req_ready) busy_ready_seen = 1;
         @(negedge clk);
         t++;
      end
      if (t >= 200) chk(1'b0, "R10 response timeout", 32'(t), 32'd200);
      ok   = rsp_ok;
      d    = rsp_rdata;
      nc   = ncyc_cnt - c0;
      la   = last_addr;
      mode = cfg_mode;
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : main
      logic        ok, mode;
      logic [31:0] d, la;
      int          nc;
      vec_t        v;

      repeat (3) @(negedge clk);
      // R11 reset state
      chk(req_ready == 1'b1, "R11 req_ready in reset", 32'(req_ready), 32'd1);
      chk(rsp_valid == 1'b0, "R11 rsp_valid in reset", 32'(rsp_valid), 32'd0);
      chk(cyc_valid == 1'b0, "R11 cyc_valid in reset", 32'(cyc_valid), 32'd0);
      chk(cfg_mode == 1'b0, "R11 cfg_mode in reset", 32'(cfg_mode), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R11 req_ready after reset", 32'(req_ready), 32'd1);

      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         do_req(v, ok, d, nc, la, mode);
         chk(ok == v.ok, $sformatf("R2 R3 R6 R7 status vec %0d", i), 32'(ok), 32'(v.ok));
         chk(d == v.rdata, $sformatf("R4 R5 data vec %0d", i), d, v.rdata);
         chk(nc == int'(v.ncyc), $sformatf("R2 R5 R6 bus cycles vec %0d", i),
             32'(nc), 32'(v.ncyc));
         if (v.ncyc != 0)
            chk(la == v.addr, $sformatf("R1 address vec %0d", i), la, v.addr);
         chk(mode == 1'b0, $sformatf("R9 mode restored vec %0d", i), 32'(mode), 32'd0);
      end

      // R8: abort raised while idle must not fail the next access
      @(negedge clk);
      force_abort = 1'b1;
      repeat (2) @(negedge clk);
      force_abort = 1'b0;
      v = VEC[0];
      do_req(v, ok, d, nc, la, mode);
      chk(ok == 1'b1, "R8 stale abort status", 32'(ok), 32'd1);
      chk(d == 32'hA100BEEF, "R8 stale abort data", d, 32'hA100BEEF);

      repeat (3) @(negedge clk);
      chk(mode_bad == 0, "R9 cycle issued outside config mode", 32'(mode_bad), 32'd0);
      chk(n_acc == n_req, "R10 accepts per request", 32'(n_acc), 32'(n_req));
      chk(n_rsp == n_req, "R10 one response per request", 32'(n_rsp), 32'(n_req));
      chk(n_double == 0, "R10 response longer than one cycle", 32'(n_double), 32'd0);
      chk(busy_ready_seen == 0, "R10 ready high while busy", 32'(busy_ready_seen), 32'd0);
      finish_run();
   end
endmodule